// File: doc/BRIEF.md
# Dual-Issue Pairing Gate

This block sits at the decode stage of a two-wide, in-order pipeline. Each cycle it sees two pre-decoded instructions: an older one and a younger one. It also keeps a scoreboard of results that earlier instructions have not yet written back. From these it decides whether both instructions issue, only the older one issues, or neither issues. When only the older one issues, the younger instruction is expected to move into the older slot in the next cycle. The gate never issues the younger slot ahead of the older one.

Each slot is described by a small descriptor:
- a resource class;
- up to two source registers and one destination register, each with an enable;
- condition-flag read and write bits;
- for the older slot only, multi-cycle, 32-bit-length and taken-delayed-branch markers;
- a marker for instructions that touch the FP unit or its status/control register.

Register indices 0 to 15 name general registers and 16 to 31 name FP registers. Each register has its own pending counter in the scoreboard. The counter is loaded with a latency chosen by the issuing instruction's class and counts down to zero, at which point the result counts as written back.

Top module: `pair_issue_gate`

## Requirements
- R1: A synchronous active-high reset holds `issue_old`, `issue_young` and `stall` low while it is asserted, and it clears every scoreboard entry, so a reader of any register can issue right after reset.
- R2: The older slot issues when `o_valid` is high and neither of its enabled sources is pending; `stall` is high exactly when `o_valid` is high and the older slot does not issue.
- R3: The younger slot never issues unless the older slot issues in the same cycle.
- R4: Resource classes are encoded 0 = integer ALU, 1 = memory, 2 = multiply, 3 = FP. Two instructions of the same class never issue together.
- R5: The pair is split on a register clash: a younger source equals the older destination, both destinations are equal, or the younger destination equals an older source (enabled fields only).
- R6: The pair is split when either instruction writes the condition flag and the other reads or writes it.
- R7: The pair is split when the older instruction is multi-cycle (`o_multi`) or 32 bits long (`o_wide`).
- R8: The pair is split when either instruction is FP-unit or FP-status related (`o_fpu` / `y_fpu`).
- R9: The pair is split when the older instruction is a taken delayed branch (`o_dbr_taken`), so its delay slot issues alone.
- R10: A destination issued at a clock edge stays pending for L cycles, where L = 1 (ALU), 2 (memory), 3 (multiply) or 4 (FP). A reader in the older slot stalls for exactly those L cycles and issues in the cycle after.
- R11: A pending source in the younger slot blocks only the younger slot; the older slot still issues.
- R12: With `y_valid` low the younger slot does not issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| o_valid | input | 1 | Older slot holds a decoded instruction |
| o_class | input | 2 | Older resource class |
| o_src_a | input | 5 | Older first source register |
| o_src_a_en | input | 1 | Older first source used |
| o_src_b | input | 5 | Older second source register |
| o_src_b_en | input | 1 | Older second source used |
| o_dst | input | 5 | Older destination register |
| o_dst_en | input | 1 | Older destination written |
| o_flag_rd | input | 1 | Older reads the condition flag |
| o_flag_wr | input | 1 | Older writes the condition flag |
| o_multi | input | 1 | Older is multi-cycle |
| o_wide | input | 1 | Older is a 32-bit instruction |
| o_fpu | input | 1 | Older is FP-unit or FP-status related |
| o_dbr_taken | input | 1 | Older is a taken delayed branch |
| y_valid | input | 1 | Younger slot holds a decoded instruction |
| y_class | input | 2 | Younger resource class |
| y_src_a | input | 5 | Younger first source register |
| y_src_a_en | input | 1 | Younger first source used |
| y_src_b | input | 5 | Younger second source register |
| y_src_b_en | input | 1 | Younger second source used |
| y_dst | input | 5 | Younger destination register |
| y_dst_en | input | 1 | Younger destination written |
| y_flag_rd | input | 1 | Younger reads the condition flag |
| y_flag_wr | input | 1 | Younger writes the condition flag |
| y_fpu | input | 1 | Younger is FP-unit or FP-status related |
| issue_old | output | 1 | Older slot issues this cycle |
| issue_young | output | 1 | Younger slot issues this cycle |
| stall | output | 1 | Older slot is valid but held |

## Verification
The issue decision is combinational, so both issue enables and `stall` settle in the same cycle the descriptors are applied. The bench drives each descriptor set just after a falling edge and samples the outputs one nanosecond later, before the next rising edge. Scoreboard effects appear only after a rising edge. A destination issued at edge t keeps readers stalled in the L cycles that follow and lets them through in cycle L+1. The bench therefore queues one expectation per cycle, including each stall cycle, so that every latency boundary is checked on the exact cycle. Tests of pairing rules read only registers that no earlier step has written, so a leftover pending entry cannot mask a rule.

// File: rtl/pair_pkg.sv
package pair_pkg;

  typedef enum logic [1:0] {
    RC_ALU = 2'd0,
    RC_MEM = 2'd1,
    RC_MUL = 2'd2,
    RC_FPU = 2'd3
  } rclass_e;

  // True when an enabled field names the same register as another enabled field.
  function automatic logic same_reg(input logic [7:0] a, input logic a_en,
                                    input logic [7:0] b, input logic b_en);
    return a_en && b_en && (a == b);
  endfunction

  // Condition flag clash: one side writes and the other touches it.
  function automatic logic flag_clash(input logic a_rd, input logic a_wr,
                                      input logic b_rd, input logic b_wr);
    return (a_wr && (b_rd || b_wr)) || (b_wr && (a_rd || a_wr));
  endfunction

endpackage

// File: rtl/pair_scoreboard.sv
module pair_scoreboard #(
  parameter int NENT    = 32,
  parameter int IW      = 5,
  parameter int LAT_ALU = 1,
  parameter int LAT_MEM = 2,
  parameter int LAT_MUL = 3,
  parameter int LAT_FPU = 4,
  parameter int CW      = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wa_en,
  input  logic [IW-1:0]   wa_idx,
  input  logic [1:0]      wa_cls,
  input  logic            wb_en,
  input  logic [IW-1:0]   wb_idx,
  input  logic [1:0]      wb_cls,
  output logic [NENT-1:0] busy
);
  import pair_pkg::*;

  function automatic logic [CW-1:0] lat_of(input logic [1:0] c);
    case (rclass_e'(c))
      RC_ALU:  return CW'(LAT_ALU);
      RC_MEM:  return CW'(LAT_MEM);
      RC_MUL:  return CW'(LAT_MUL);
      default: return CW'(LAT_FPU);
    endcase
  endfunction

  logic [CW-1:0] lat_a, lat_b;
  assign lat_a = lat_of(wa_cls);
  assign lat_b = lat_of(wb_cls);

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    logic [CW-1:0] cnt;
    logic          hit_a, hit_b;
    assign hit_a = wa_en && (wa_idx == IW'(g));
    assign hit_b = wb_en && (wb_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (rst)               cnt <= '0;
      else if (hit_b)        cnt <= lat_b;
      else if (hit_a)        cnt <= lat_a;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
    end
    assign busy[g] = (cnt != '0);
  end

  AST_SB_SET_A: assert property (@(posedge clk) disable iff (rst)
    wa_en |=> busy[$past(wa_idx)]); // R10
  AST_SB_SET_B: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> busy[$past(wb_idx)]); // R10
  AST_SB_CLEARED: assert property (@(posedge clk)
    rst |=> (busy == '0)); // R1

endmodule

// File: rtl/pair_src_check.sv
module pair_src_check #(
  parameter int NENT = 32,
  parameter int IW   = 5
) (
  input  logic [NENT-1:0] busy,
  input  logic [IW-1:0]   src_a,
  input  logic            src_a_en,
  input  logic [IW-1:0]   src_b,
  input  logic            src_b_en,
  output logic            pend
);
  logic pend_a, pend_b;
  assign pend_a = src_a_en && busy[src_a];
  assign pend_b = src_b_en && busy[src_b];
  assign pend   = pend_a || pend_b;
endmodule

// File: rtl/pair_rules.sv
module pair_rules #(
  parameter int IW = 5
) (
  input  logic [1:0]    o_class,
  input  logic [IW-1:0] o_src_a,
  input  logic          o_src_a_en,
  input  logic [IW-1:0] o_src_b,
  input  logic          o_src_b_en,
  input  logic [IW-1:0] o_dst,
  input  logic          o_dst_en,
  input  logic          o_flag_rd,
  input  logic          o_flag_wr,
  input  logic          o_multi,
  input  logic          o_wide,
  input  logic          o_fpu,
  input  logic          o_dbr_taken,
  input  logic [1:0]    y_class,
  input  logic [IW-1:0] y_src_a,
  input  logic          y_src_a_en,
  input  logic [IW-1:0] y_src_b,
  input  logic          y_src_b_en,
  input  logic [IW-1:0] y_dst,
  input  logic          y_dst_en,
  input  logic          y_flag_rd,
  input  logic          y_flag_wr,
  input  logic          y_fpu,
  output logic          blk_class,
  output logic          blk_reg,
  output logic          blk_flag,
  output logic          blk_shape,
  output logic          blk_fpu,
  output logic          blk_branch,
  output logic          pair_ok
);
  import pair_pkg::*;

  logic raw_a, raw_b, waw, war_a, war_b;
  assign raw_a = same_reg(8'(y_src_a), y_src_a_en, 8'(o_dst), o_dst_en);
  assign raw_b = same_reg(8'(y_src_b), y_src_b_en, 8'(o_dst), o_dst_en);
  assign waw   = same_reg(8'(y_dst), y_dst_en, 8'(o_dst), o_dst_en);
  assign war_a = same_reg(8'(y_dst), y_dst_en, 8'(o_src_a), o_src_a_en);
  assign war_b = same_reg(8'(y_dst), y_dst_en, 8'(o_src_b), o_src_b_en);

  assign blk_class  = (o_class == y_class);
  assign blk_reg    = raw_a || raw_b || waw || war_a || war_b;
  assign blk_flag   = flag_clash(o_flag_rd, o_flag_wr, y_flag_rd, y_flag_wr);
  assign blk_shape  = o_multi || o_wide;
  assign blk_fpu    = o_fpu || y_fpu;
  assign blk_branch = o_dbr_taken;
  assign pair_ok    = !(blk_class || blk_reg || blk_flag ||
                        blk_shape || blk_fpu || blk_branch);
endmodule

// File: rtl/pair_issue_gate.sv
module pair_issue_gate #(
  parameter int NGPR    = 16,
  parameter int NFPR    = 16,
  parameter int LAT_ALU = 1,
  parameter int LAT_MEM = 2,
  parameter int LAT_MUL = 3,
  parameter int LAT_FPU = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       o_valid,
  input  logic [1:0] o_class,
  input  logic [4:0] o_src_a,
  input  logic       o_src_a_en,
  input  logic [4:0] o_src_b,
  input  logic       o_src_b_en,
  input  logic [4:0] o_dst,
  input  logic       o_dst_en,
  input  logic       o_flag_rd,
  input  logic       o_flag_wr,
  input  logic       o_multi,
  input  logic       o_wide,
  input  logic       o_fpu,
  input  logic       o_dbr_taken,
  input  logic       y_valid,
  input  logic [1:0] y_class,
  input  logic [4:0] y_src_a,
  input  logic       y_src_a_en,
  input  logic [4:0] y_src_b,
  input  logic       y_src_b_en,
  input  logic [4:0] y_dst,
  input  logic       y_dst_en,
  input  logic       y_flag_rd,
  input  logic       y_flag_wr,
  input  logic       y_fpu,
  output logic       issue_old,
  output logic       issue_young,
  output logic       stall
);
  localparam int NENT   = NGPR + NFPR;
  localparam int IW     = 5;
  localparam int LMAX_A = (LAT_ALU > LAT_MEM) ? LAT_ALU : LAT_MEM;
  localparam int LMAX_B = (LAT_MUL > LAT_FPU) ? LAT_MUL : LAT_FPU;
  localparam int LMAX   = (LMAX_A > LMAX_B) ? LMAX_A : LMAX_B;
  localparam int CW     = $clog2(LMAX + 1);

  logic [NENT-1:0] busy;
  logic o_pend, y_pend;
  logic blk_class, blk_reg, blk_flag, blk_shape, blk_fpu, blk_branch, pair_ok;

  pair_scoreboard #(
    .NENT(NENT), .IW(IW), .LAT_ALU(LAT_ALU), .LAT_MEM(LAT_MEM),
    .LAT_MUL(LAT_MUL), .LAT_FPU(LAT_FPU), .CW(CW)
  ) u_sb (
    .clk(clk), .rst(rst),
    .wa_en(issue_old && o_dst_en), .wa_idx(o_dst), .wa_cls(o_class),
    .wb_en(issue_young && y_dst_en), .wb_idx(y_dst), .wb_cls(y_class),
    .busy(busy)
  );

  pair_src_check #(.NENT(NENT), .IW(IW)) u_chk_old (
    .busy(busy), .src_a(o_src_a), .src_a_en(o_src_a_en),
    .src_b(o_src_b), .src_b_en(o_src_b_en), .pend(o_pend)
  );

  pair_src_check #(.NENT(NENT), .IW(IW)) u_chk_young (
    .busy(busy), .src_a(y_src_a), .src_a_en(y_src_a_en),
    .src_b(y_src_b), .src_b_en(y_src_b_en), .pend(y_pend)
  );

  pair_rules #(.IW(IW)) u_rules (
    .o_class(o_class), .o_src_a(o_src_a), .o_src_a_en(o_src_a_en),
    .o_src_b(o_src_b), .o_src_b_en(o_src_b_en), .o_dst(o_dst),
    .o_dst_en(o_dst_en), .o_flag_rd(o_flag_rd), .o_flag_wr(o_flag_wr),
    .o_multi(o_multi), .o_wide(o_wide), .o_fpu(o_fpu),
    .o_dbr_taken(o_dbr_taken),
    .y_class(y_class), .y_src_a(y_src_a), .y_src_a_en(y_src_a_en),
    .y_src_b(y_src_b), .y_src_b_en(y_src_b_en), .y_dst(y_dst),
    .y_dst_en(y_dst_en), .y_flag_rd(y_flag_rd), .y_flag_wr(y_flag_wr),
    .y_fpu(y_fpu),
    .blk_class(blk_class), .blk_reg(blk_reg), .blk_flag(blk_flag),
    .blk_shape(blk_shape), .blk_fpu(blk_fpu), .blk_branch(blk_branch),
    .pair_ok(pair_ok)
  );

  assign issue_old   = !rst && o_valid && !o_pend;
  assign issue_young = issue_old && y_valid && pair_ok && !y_pend;
  assign stall       = !rst && o_valid && !issue_old;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> (!issue_old && !issue_young && !stall)); // R1
  AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (rst)
    issue_young |-> issue_old); // R3
  AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    stall |-> (!issue_old && !issue_young)); // R2
  AST_SAME_CLASS: assert property (@(posedge clk) disable iff (rst)
    (o_class == y_class) |-> !issue_young); // R4
  AST_SHAPE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (o_multi || o_wide) |-> !issue_young); // R7
  AST_FPU_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (o_fpu || y_fpu) |-> !issue_young); // R8
  AST_BRANCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    o_dbr_taken |-> !issue_young); // R9
  AST_YOUNG_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    !y_valid |-> !issue_young); // R12

endmodule

// File: tb/pair_issue_gate_tb.sv
module pair_issue_gate_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic o_valid, o_src_a_en, o_src_b_en, o_dst_en, o_flag_rd, o_flag_wr;
  logic o_multi, o_wide, o_fpu, o_dbr_taken;
  logic [1:0] o_class, y_class;
  logic [4:0] o_src_a, o_src_b, o_dst, y_src_a, y_src_b, y_dst;
  logic y_valid, y_src_a_en, y_src_b_en, y_dst_en, y_flag_rd, y_flag_wr, y_fpu;
  logic issue_old, issue_young, stall;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic eo; logic ey; logic es; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  pair_issue_gate u_dut (
    .clk(clk), .rst(rst),
    .o_valid(o_valid), .o_class(o_class), .o_src_a(o_src_a),
    .o_src_a_en(o_src_a_en), .o_src_b(o_src_b), .o_src_b_en(o_src_b_en),
    .o_dst(o_dst), .o_dst_en(o_dst_en), .o_flag_rd(o_flag_rd),
    .o_flag_wr(o_flag_wr), .o_multi(o_multi), .o_wide(o_wide),
    .o_fpu(o_fpu), .o_dbr_taken(o_dbr_taken),
    .y_valid(y_valid), .y_class(y_class), .y_src_a(y_src_a),
    .y_src_a_en(y_src_a_en), .y_src_b(y_src_b), .y_src_b_en(y_src_b_en),
    .y_dst(y_dst), .y_dst_en(y_dst_en), .y_flag_rd(y_flag_rd),
    .y_flag_wr(y_flag_wr), .y_fpu(y_fpu),
    .issue_old(issue_old), .issue_young(issue_young), .stall(stall)
  );

  task automatic nop();
    o_valid = 0; o_class = 0; o_src_a = 0; o_src_a_en = 0; o_src_b = 0;
    o_src_b_en = 0; o_dst = 0; o_dst_en = 0; o_flag_rd = 0; o_flag_wr = 0;
    o_multi = 0; o_wide = 0; o_fpu = 0; o_dbr_taken = 0;
    y_valid = 0; y_class = 0; y_src_a = 0; y_src_a_en = 0; y_src_b = 0;
    y_src_b_en = 0; y_dst = 0; y_dst_en = 0; y_flag_rd = 0; y_flag_wr = 0;
    y_fpu = 0;
  endtask

  task automatic old_op(input logic [1:0] c, input logic [4:0] s, input logic [4:0] d);
    o_valid = 1; o_class = c; o_src_a = s; o_src_a_en = 1; o_dst = d; o_dst_en = 1;
  endtask

  task automatic young_op(input logic [1:0] c, input logic [4:0] s, input logic [4:0] d);
    y_valid = 1; y_class = c; y_src_a = s; y_src_a_en = 1; y_dst = d; y_dst_en = 1;
  endtask

  task automatic expect_cyc(input logic eo, input logic ey, input logic es, input string tag);
    exp_t e;
    e.eo = eo; e.ey = ey; e.es = es; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares one queued expectation per cycle, 1 ns after the falling edge.
  initial forever begin
    @(negedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({issue_old, issue_young, stall} !== {e.eo, e.ey, e.es}) begin
        errors++;
        $display("FAIL %s: got old=%b young=%b stall=%b expected old=%b young=%b stall=%b",
                 e.tag, issue_old, issue_young, stall, e.eo, e.ey, e.es);
      end
    end
  end

  initial begin
    #80000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    nop();
    // R1: reset holds everything low even with valid inputs
    @(negedge clk); nop(); old_op(0, 0, 8); young_op(1, 1, 9); expect_cyc(0, 0, 0, "R1 reset");
    @(negedge clk); rst = 0; nop(); old_op(0, 0, 8); young_op(1, 1, 9);
    expect_cyc(1, 1, 0, "R2 independent pair");
    // R4 same class
    @(negedge clk); nop(); old_op(0, 0, 10); young_op(0, 1, 11); expect_cyc(1, 0, 0, "R4 same class");
    @(negedge clk); nop(); old_op(2, 0, 10); young_op(3, 1, 11); expect_cyc(1, 1, 0, "R4 mul+fpclass pair");
    // R5 register clashes
    @(negedge clk); nop(); old_op(0, 0, 12); young_op(1, 12, 13); expect_cyc(1, 0, 0, "R5 raw");
    @(negedge clk); nop(); old_op(0, 0, 14); young_op(1, 1, 14); expect_cyc(1, 0, 0, "R5 waw");
    @(negedge clk); nop(); old_op(0, 6, 15); young_op(1, 1, 6); expect_cyc(1, 0, 0, "R5 war");
    // R6 flags
    @(negedge clk); nop(); old_op(0, 0, 8); young_op(1, 1, 9); o_flag_wr = 1; y_flag_rd = 1;
    expect_cyc(1, 0, 0, "R6 flag write/read");
    @(negedge clk); nop(); old_op(0, 0, 8); young_op(1, 1, 9); o_flag_rd = 1; y_flag_rd = 1;
    expect_cyc(1, 1, 0, "R6 both read");
    // R7 shape
    @(negedge clk); nop(); old_op(0, 0, 8); young_op(1, 1, 9); o_multi = 1; expect_cyc(1, 0, 0, "R7 multi");
    @(negedge clk); nop(); old_op(0, 0, 8); young_op(1, 1, 9); o_wide = 1; expect_cyc(1, 0, 0, "R7 wide");
    // R8 fp related
    @(negedge clk); nop(); old_op(0, 0, 8); young_op(1, 1, 9); y_fpu = 1; expect_cyc(1, 0, 0, "R8 young fpu");
    @(negedge clk); nop(); old_op(1, 0, 8); young_op(0, 1, 9); o_fpu = 1; expect_cyc(1, 0, 0, "R8 old fpu");
    // R9 taken delayed branch
    @(negedge clk); nop(); old_op(0, 0, 8); young_op(1, 1, 9); o_dbr_taken = 1;
    expect_cyc(1, 0, 0, "R9 delay slot");
    // R12 / R3
    @(negedge clk); nop(); old_op(0, 0, 8); expect_cyc(1, 0, 0, "R12 young invalid");
    @(negedge clk); nop(); young_op(1, 1, 9); expect_cyc(0, 0, 0, "R3 old invalid");
    // R10 multiply latency 3
    @(negedge clk); nop(); old_op(2, 0, 3); expect_cyc(1, 0, 0, "R10 mul issue");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); nop(); old_op(0, 3, 16); expect_cyc(0, 0, 1, "R10 mul pending");
    end
    @(negedge clk); nop(); old_op(0, 3, 16); expect_cyc(1, 0, 0, "R10 mul done");
    // R10 memory latency 2, source in second field
    @(negedge clk); nop(); old_op(1, 0, 2); expect_cyc(1, 0, 0, "R10 mem issue");
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); nop(); old_op(0, 0, 17); o_src_b = 2; o_src_b_en = 1;
      expect_cyc(0, 0, 1, "R10 mem pending");
    end
    @(negedge clk); nop(); old_op(0, 0, 17); o_src_b = 2; o_src_b_en = 1;
    expect_cyc(1, 0, 0, "R10 mem done");
    // R11 young pending blocks only young
    @(negedge clk); nop(); old_op(2, 0, 4); expect_cyc(1, 0, 0, "R11 setup");
    @(negedge clk); nop(); old_op(0, 0, 10); young_op(1, 4, 11); expect_cyc(1, 0, 0, "R11 young pending");
    // R1 scoreboard cleared by reset
    @(negedge clk); nop(); old_op(3, 0, 5); o_fpu = 1; expect_cyc(1, 0, 0, "R1 fp write");
    @(negedge clk); rst = 1; nop(); expect_cyc(0, 0, 0, "R1 reset pulse");
    @(negedge clk); rst = 0; nop(); old_op(0, 5, 18); expect_cyc(1, 0, 0, "R1 cleared entry");
    @(negedge clk); nop();
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule